// File: doc/BRIEF.md
# Overflow-Set Compare-Clear PWM Timer

This block is an up-counting timer of `CNT_W` bits (8 by default) that drives one pulse-width-modulated pin. A prescaler gives a count clock that is the system clock divided by 1, 4, 16 or 64. While the timer runs, the pulse becomes active each time the counter wraps from its top value to zero. It becomes inactive again when the count reaches the compare value. The period is therefore 2^CNT_W count clocks, and the active width is N count clocks for a compare value N.

Software programs the block through a write-only port with three registers. The control register holds the run bit, the polarity bit and the pin-enable bit. The clock-select register holds the prescaler choice. The compare register holds N. A compare value written while the timer runs goes to a buffer and is used from the next wrap. Any period therefore uses a single compare value. Stopping clears the counter and makes the output inactive, so every restart begins from zero.

Top module: `ovf_pwm_timer`

## Requirements
- R1: After reset the timer is stopped, every register is zero and `pwm_out` is 0.
- R2: Address 0 is the control register; bit 0 = run. After the edge that writes run=1, the output stays inactive until the first wrap. With divisor D it first turns active in the cycle after 256·D clock edges.
- R3: On each wrap the output becomes active. It becomes inactive when the count reaches the compare value N (address 2). That gives N·D active cycles in a period of 256·D cycles.
- R4: With N = 0 the output never becomes active, because the compare match at count 0 outranks the set from the wrap.
- R5: The edge that writes run=0 makes the output inactive from the next cycle and clears the count. The next start again waits 256·D cycles for the first active level.
- R6: Control bit 1 = 1 selects an active-low pulse. The pin is then 1 while the pulse is inactive and 0 while it is active. With bit 1 = 0 the pulse is active-high.
- R7: Control bit 2 enables the pin. While it is 0, `pwm_out` is 0 whatever the pulse state.
- R8: Address 1, bits [1:0], selects the divisor D = 4^sel, which is 1, 4, 16 or 64.
- R9: A write to the clock-select register while the timer runs is ignored, so the period and the width keep their values.
- R10: A compare write while the timer runs does not change the current period. It takes effect from the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 clock select, 2 compare) |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 2-bit select. With these values all four divisors can be reached, including the longest period of 16384 cycles. The compare extremes 00h, 01h and FFh give zero, one-count and near-full widths. A cycle-by-cycle model checks the pin during random sequences of writes, stops and restarts. Directed runs measure the start delay, the active width and the inactive width.

// File: rtl/ovf_pwm_pkg.sv
package ovf_pwm_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CLKSEL = 2'd1,
        REG_CMP    = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;

    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_LOWACT_BIT = 1;
    localparam int CTRL_OE_BIT     = 2;
endpackage

// File: rtl/ovf_pwm_regs.sv
module ovf_pwm_regs #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             run_q,
    output logic             low_act_q,
    output logic             oe_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [CNT_W-1:0] cmp_buf_q
);
    import ovf_pwm_pkg::*;

    typedef struct packed {
        logic             run;
        logic             low_act;
        logic             oe;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cmp_buf;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    r_d.run     = wr_data[CTRL_RUN_BIT];
                    r_d.low_act = wr_data[CTRL_LOWACT_BIT];
                    r_d.oe      = wr_data[CTRL_OE_BIT];
                end
                REG_CLKSEL: begin
                    if (!r_q.run) r_d.sel = wr_data[SEL_W-1:0];
                end
                REG_CMP: r_d.cmp_buf = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run_q     = r_q.run;
    assign low_act_q = r_q.low_act;
    assign oe_q      = r_q.oe;
    assign sel_q     = r_q.sel;
    assign cmp_buf_q = r_q.cmp_buf;
endmodule

// File: rtl/ovf_pwm_prescale.sv
module ovf_pwm_prescale #(
    parameter int SEL_W    = 2,
    parameter int DIV_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W_RAW = DIV_STEP * ((1 << SEL_W) - 1);
    localparam int PRE_W     = (PRE_W_RAW < 1) ? 1 : PRE_W_RAW;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t p_d, p_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span  = (PRE_W+1)'(1) << (DIV_STEP * int'(sel));
        limit = span[PRE_W-1:0] - PRE_W'(1);
        tick  = run && (p_q.pre == limit);
        p_d   = p_q;
        if (!run)      p_d.pre = '0;
        else if (tick) p_d.pre = '0;
        else           p_d.pre = p_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/ovf_pwm_core.sv
module ovf_pwm_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_act_q,
    output logic             act_q,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             act;
    } core_t;

    core_t c_d, c_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        ovf     = tick && (c_q.cnt == CNT_TOP);
        cnt_inc = c_q.cnt + CNT_W'(1);
        c_d     = c_q;
        if (!run) begin
            c_d.cnt = '0;
            c_d.act = 1'b0;
            c_d.cmp = cmp_buf;
        end else if (ovf) begin
            c_d.cnt = '0;
            c_d.cmp = cmp_buf;
            c_d.act = (cmp_buf != '0);
        end else if (tick) begin
            c_d.cnt = cnt_inc;
            if (cnt_inc == c_q.cmp) c_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_q     = c_q.cnt;
    assign cmp_act_q = c_q.cmp;
    assign act_q     = c_q.act;
endmodule

// File: rtl/ovf_pwm_timer.sv
module ovf_pwm_timer #(
    parameter int CNT_W    = 8,
    parameter int SEL_W    = 2,
    parameter int DIV_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);
    logic             run_q, low_act_q, oe_q, tick, act_q, ovf;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_buf_q, cnt_q, cmp_act_q;

    ovf_pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run_q(run_q), .low_act_q(low_act_q),
        .oe_q(oe_q), .sel_q(sel_q), .cmp_buf_q(cmp_buf_q)
    );

    ovf_pwm_prescale #(.SEL_W(SEL_W), .DIV_STEP(DIV_STEP)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .sel(sel_q), .tick(tick)
    );

    ovf_pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick),
        .cmp_buf(cmp_buf_q), .cnt_q(cnt_q), .cmp_act_q(cmp_act_q),
        .act_q(act_q), .ovf(ovf)
    );

    // Pulse is gated by run so a stop shows inactive in the very next cycle.
    assign pwm_out = oe_q & ((act_q & run_q) ^ low_act_q);
endmodule

// File: rtl/ovf_pwm_checker.sv
module ovf_pwm_checker #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             pwm_out,
    input logic             run_q,
    input logic [SEL_W-1:0] sel_q,
    input logic [CNT_W-1:0] cmp_buf_q,
    input logic [CNT_W-1:0] cmp_act_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             act_q,
    input logic             ovf
);
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && !wr_data[2]) |=> !pwm_out);

    a_r5_stop_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && !wr_data[0])
            |=> (pwm_out == ($past(wr_data[2]) & $past(wr_data[1]))));

    a_r3_active_below_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (cnt_q < cmp_act_q));

    a_r4_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && cmp_buf_q == '0) |=> !act_q);

    a_r9_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(sel_q));

    a_r10_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(ovf)) |-> $stable(cmp_act_q));

    a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (!act_q && cnt_q == '0));
endmodule

bind ovf_pwm_timer ovf_pwm_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .run_q(run_q), .sel_q(sel_q),
    .cmp_buf_q(cmp_buf_q), .cmp_act_q(cmp_act_q), .cnt_q(cnt_q),
    .act_q(act_q), .ovf(ovf)
);

// File: tb/ovf_pwm_timer_test.sv
module ovf_pwm_timer_test;
    localparam int CNT_W = 8;
    localparam int PER   = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    ovf_pwm_timer #(.CNT_W(CNT_W), .SEL_W(2), .DIV_STEP(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    function automatic int divisor(input int sel);
        return 4 ** sel;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    bit m_run, m_low, m_oe, m_act;
    int m_sel, m_buf, m_cmp, m_pre, m_cnt;

    function automatic bit exp_pin();
        return m_oe & ((m_act & m_run) ^ m_low);
    endfunction

    always @(posedge clk) begin : model
        bit tk, wrap;
        if (!rst_n) begin
            m_run <= 0; m_low <= 0; m_oe <= 0; m_act <= 0;
            m_sel <= 0; m_buf <= 0; m_cmp <= 0; m_pre <= 0; m_cnt <= 0;
        end else begin
            tk   = m_run && (m_pre == divisor(m_sel) - 1);
            wrap = tk && (m_cnt == PER - 1);
            if (!m_run) begin
                m_pre <= 0; m_cnt <= 0; m_act <= 0; m_cmp <= m_buf;
            end else begin
                m_pre <= tk ? 0 : m_pre + 1;
                if (wrap) begin
                    m_cnt <= 0; m_cmp <= m_buf; m_act <= (m_buf != 0);
                end else if (tk) begin
                    m_cnt <= m_cnt + 1;
                    if (m_cnt + 1 == m_cmp) m_act <= 0;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_run <= wr_data[0]; m_low <= wr_data[1]; m_oe <= wr_data[2]; end
                    2'd1: if (!m_run) m_sel <= int'(wr_data[1:0]);
                    2'd2: m_buf <= int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on && !done)
            chk(pwm_out == exp_pin(), "R3 model pin", int'(pwm_out), int'(exp_pin()));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 195000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_until(input bit level, input int limit, output int n);
        n = 0;
        while (pwm_out != level && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_level(input bit level, input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out == level) n++;
        end
    endtask

    task automatic stop_timer();
        wr(0, 3'b100);
        wr(0, 3'b000);
    endtask

    initial begin : stim
        int n;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(pwm_out == 1'b0, "R1 reset pin", int'(pwm_out), 0);
        rst_n = 1'b1;
        count_level(1'b1, 20, n);
        chk(n == 0, "R1 idle after reset", n, 0);
        model_on = 1'b1;

        // R2 / R3: start delay, width and gap at divisor 1
        wr(2, 128); wr(1, 0); wr(0, 3'b101);
        count_until(1'b1, 2000, n); chk(n == PER, "R2 first active delay", n, PER);
        count_until(1'b0, 2000, n); chk(n == 128, "R3 width N=128", n, 128);
        count_until(1'b1, 2000, n); chk(n == 128, "R3 gap N=128", n, 128);

        // R5: stop makes inactive at once, restart from zero
        wr(0, 3'b100);
        chk(pwm_out == 1'b0, "R5 stop inactive", int'(pwm_out), 0);
        wr(0, 3'b101);
        count_until(1'b1, 2000, n); chk(n == PER, "R5 restart delay", n, PER);

        // R4: compare 0 never active
        stop_timer(); wr(2, 0); wr(0, 3'b101);
        count_level(1'b1, 3 * PER + 10, n); chk(n == 0, "R4 zero duty", n, 0);

        // R3 extremes
        stop_timer(); wr(2, 255); wr(0, 3'b101);
        count_until(1'b1, 2000, n);
        count_until(1'b0, 2000, n); chk(n == 255, "R3 width N=255", n, 255);
        stop_timer(); wr(2, 1); wr(0, 3'b101);
        count_until(1'b1, 2000, n);
        count_until(1'b0, 2000, n); chk(n == 1, "R3 width N=1", n, 1);

        // R6: active-low
        stop_timer(); wr(2, 64); wr(0, 3'b111);
        chk(pwm_out == 1'b1, "R6 idle high when active-low", int'(pwm_out), 1);
        count_until(1'b0, 2000, n); chk(n == PER, "R6 first low", n, PER);
        count_until(1'b1, 2000, n); chk(n == 64, "R6 low width", n, 64);

        // R7: pin disabled
        stop_timer(); wr(0, 3'b011);
        count_level(1'b1, 2 * PER + 10, n); chk(n == 0, "R7 pin off", n, 0);

        // R8: divisor 16 and 64
        stop_timer(); wr(1, 2); wr(2, 10); wr(0, 3'b101);
        count_until(1'b1, 20000, n); chk(n == PER * 16, "R8 delay div16", n, PER * 16);
        count_until(1'b0, 20000, n); chk(n == 160, "R8 width div16", n, 160);
        stop_timer(); wr(1, 3); wr(2, 2); wr(0, 3'b101);
        count_until(1'b1, 20000, n); chk(n == PER * 64, "R8 delay div64", n, PER * 64);
        count_until(1'b0, 20000, n); chk(n == 128, "R8 width div64", n, 128);

        // R9: select write while running ignored
        stop_timer(); wr(1, 0); wr(2, 50); wr(0, 3'b101);
        wr(1, 3);
        count_until(1'b1, 20000, n);
        count_until(1'b0, 20000, n); chk(n == 50, "R9 width kept", n, 50);
        count_until(1'b1, 20000, n); chk(n == PER - 50, "R9 gap kept", n, PER - 50);

        // R10: compare write during an active phase
        stop_timer(); wr(2, 40); wr(0, 3'b101);
        count_until(1'b1, 2000, n);
        wr(2, 200);
        count_until(1'b0, 2000, n); chk(n + 2 == 40, "R10 current width", n + 2, 40);
        count_until(1'b1, 2000, n); chk(n == PER - 40, "R10 current gap", n, PER - 40);
        count_until(1'b0, 2000, n); chk(n == 200, "R10 next width", n, 200);

        // Random writes, stops and restarts checked by the model (R3)
        for (int k = 0; k < 40; k++) begin
            int op = int'($urandom_range(0, 3));
            case (op)
                0: wr(0, int'($urandom_range(0, 7)));
                1: wr(1, int'($urandom_range(0, 3)));
                2: wr(2, int'($urandom_range(0, 255)));
                default: wr(0, int'($urandom_range(0, 3)) * 2 + 5);
            endcase
            repeat (int'($urandom_range(1, 1500))) @(negedge clk);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule